// File: doc/BRIEF.md
# Bit-Clock Serial Audio Delay Line

This block inserts a fixed time delay into a serial digital audio link, for example to line up a tweeter feed with a mid-range driver that sits farther from the listener. The block runs on the link's own bit clock. On every rising edge it stores the pair formed by the data bit and the word-select bit. The output stays muted until the number of stored pairs reaches a threshold. From that edge on, one pair is read out for every pair written. The fill level therefore stays fixed, and the output lags the input by exactly the threshold, counted in bit periods.

Two threshold inputs are provided, one for each sample-rate family. A select input picks which of the two is captured. One bit period lasts a different time in each family, so each family needs its own count to give the same delay in milliseconds.

A watchdog runs on a free-running system clock and looks for bit-clock edges through a synchroniser. If the bit clock stops for a programmable number of system cycles, the watchdog flushes all stored audio and clears the output state. Stale samples are therefore not replayed when the source returns.

Top module: `sdl_top`

## Requirements
- R1: While `rst_n` is low, `sd_out`, `ws_out`, `dly_active` and `ovf` are all low.
- R2: After `rst_n` rises, the first two rising bit-clock edges only release the internal bit-clock reset. The third rising edge stores the first pair and captures the threshold.
- R3: The captured threshold T is `thr_fam1` when `rate_sel` is 1 and `thr_fam0` when it is 0.
- R4: Number the storing edges from 0. For a threshold T with 1 <= T <= DEPTH, `dly_active` rises at edge T. After every edge k >= T, `{sd_out, ws_out}` equals the `{sd_in, ws_in}` sampled at edge k-T.
- R5: A threshold value of 0 behaves exactly like a threshold of 1.
- R6: While `dly_active` is low, `sd_out` and `ws_out` are low.
- R7: Once `dly_active` is high it stays high, and the delay stays the same for as long as the bit clock runs. Changes on `thr_fam0`, `thr_fam1` or `rate_sel` during this time have no effect.
- R8: If T > DEPTH, storing stops once DEPTH pairs are held and further pairs are dropped. `ovf` rises after edge DEPTH and stays high, and `dly_active` never rises.
- R9: If no rising bit-clock edge arrives for TIMEOUT system cycles, the block flushes. `sd_out`, `ws_out`, `dly_active` and `ovf` go low and all stored pairs are discarded.
- R10: When the bit clock resumes after a flush, and provided its period exceeds three system cycles, the first three rising edges are discarded. The fourth edge is storing edge 0 and recaptures the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock for the watchdog |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Audio bit clock; all storage runs on its rising edge |
| sd_in | input | 1 | Serial data bit |
| ws_in | input | 1 | Word-select bit |
| rate_sel | input | 1 | Selects which threshold input is captured |
| thr_fam0 | input | clog2(DEPTH)+1 | Delay threshold in bit periods, family 0 |
| thr_fam1 | input | clog2(DEPTH)+1 | Delay threshold in bit periods, family 1 |
| sd_out | output | 1 | Delayed serial data, low while muted |
| ws_out | output | 1 | Delayed word select, low while muted |
| dly_active | output | 1 | High once the delayed stream is flowing |
| ovf | output | 1 | Sticky flag: a pair was dropped because storage was full |

## Verification
The bench builds the block with DEPTH = 16 and TIMEOUT = 32, and runs a 40 ns bit clock against the 5 ns system clock. The small depth lets a short run reach both the full-depth threshold (T = 16) and an oversized threshold that drives the storage into overflow. The short timeout lets the bench stop the bit clock and see the flush after a few dozen system cycles. It then resumes the clock with a different family selected and checks the recaptured delay.

// File: rtl/sdl_pkg.sv
`timescale 1ns/1ps
package sdl_pkg;
    // One stored bit period: data bit and word-select bit
    typedef struct packed {
        logic sd;
        logic ws;
    } bitpair_t;
endpackage

// File: rtl/sdl_store.sv
`timescale 1ns/1ps
module sdl_store #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  sdl_pkg::bitpair_t wdata,
    input  logic [AW-1:0]     raddr,
    output sdl_pkg::bitpair_t rdata
);
    sdl_pkg::bitpair_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Read is combinational: same-address read and write yields the old pair
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sdl_rst_sync.sv
`timescale 1ns/1ps
module sdl_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) stage_q[i] <= 1'b0;
                    else         stage_q[i] <= 1'b1;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) stage_q[i] <= 1'b0;
                    else         stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign srst_n = stage_q[STAGES-1];
endmodule

// File: rtl/sdl_bclk_watch.sv
`timescale 1ns/1ps
module sdl_bclk_watch #(
    parameter int TIMEOUT = 256,
    parameter int SYNC    = 2
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic bclk,
    output logic flush
);
    localparam int TW = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          prev;
        logic          flush;
    } wd_t;

    logic [SYNC-1:0] sync_q;
    logic            seen_edge;
    wd_t             wd_d, wd_q;

    generate
        for (genvar i = 0; i < SYNC; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge sys_clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= bclk;
                end
            end else begin : g_next
                always_ff @(posedge sys_clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign seen_edge = sync_q[SYNC-1] & ~wd_q.prev;

    always_comb begin
        wd_d      = wd_q;
        wd_d.prev = sync_q[SYNC-1];
        if (seen_edge) begin
            wd_d.cnt   = '0;
            wd_d.flush = 1'b0;
        end else if (wd_q.cnt != TW'(TIMEOUT)) begin
            wd_d.cnt = wd_q.cnt + 1'b1;
        end else begin
            wd_d.flush = 1'b1;
        end
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign flush = wd_q.flush;
endmodule

// File: rtl/sdl_fill_ctrl.sv
`timescale 1ns/1ps
module sdl_fill_ctrl #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic              bclk,
    input  logic              brst_n,
    input  logic              sd_in,
    input  logic              ws_in,
    input  logic              rate_sel,
    input  logic [CW-1:0]     thr_fam0,
    input  logic [CW-1:0]     thr_fam1,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output sdl_pkg::bitpair_t mem_wdata,
    output logic [AW-1:0]     mem_raddr,
    input  sdl_pkg::bitpair_t mem_rdata,
    output logic              sd_out,
    output logic              ws_out,
    output logic              active,
    output logic              ovf
);
    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [CW-1:0]     fill;
        logic [CW-1:0]     thr;
        logic              loaded;
        logic              run;
        logic              ovf;
        sdl_pkg::bitpair_t out;
    } ctl_t;

    ctl_t          st_d, st_q;
    logic [CW-1:0] thr_pick;
    logic          start, rd, wr, full;

    always_comb begin
        thr_pick = rate_sel ? thr_fam1 : thr_fam0;
        if (thr_pick == '0) thr_pick = CW'(1);

        full  = (st_q.fill == CW'(DEPTH));
        start = st_q.loaded && !st_q.run && (st_q.fill == st_q.thr);
        rd    = st_q.run || start;
        wr    = !full || rd;

        st_d = st_q;
        if (!st_q.loaded) begin
            st_d.thr    = thr_pick;
            st_d.loaded = 1'b1;
        end
        if (wr) st_d.wptr = st_q.wptr + 1'b1;
        if (rd) begin
            st_d.rptr = st_q.rptr + 1'b1;
            st_d.out  = mem_rdata;
            st_d.run  = 1'b1;
        end else begin
            st_d.out  = '0;
        end
        case ({wr, rd})
            2'b10:   st_d.fill = st_q.fill + 1'b1;
            2'b01:   st_d.fill = st_q.fill - 1'b1;
            default: st_d.fill = st_q.fill;
        endcase
        if (!wr) st_d.ovf = 1'b1;

        mem_we       = wr;
        mem_waddr    = st_q.wptr;
        mem_wdata.sd = sd_in;
        mem_wdata.ws = ws_in;
        mem_raddr    = st_q.rptr;
    end

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sd_out = st_q.out.sd;
    assign ws_out = st_q.out.ws;
    assign active = st_q.run;
    assign ovf    = st_q.ovf;
endmodule

// File: rtl/sdl_top.sv
`timescale 1ns/1ps
module sdl_top #(
    parameter int DEPTH   = 1024,
    parameter int TIMEOUT = 256,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = AW + 1
) (
    input  logic          sys_clk,
    input  logic          rst_n,
    input  logic          bclk,
    input  logic          sd_in,
    input  logic          ws_in,
    input  logic          rate_sel,
    input  logic [CW-1:0] thr_fam0,
    input  logic [CW-1:0] thr_fam1,
    output logic          sd_out,
    output logic          ws_out,
    output logic          dly_active,
    output logic          ovf
);
    logic              flush;
    logic              arst_b_n;
    logic              brst_n;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    sdl_pkg::bitpair_t mem_wdata, mem_rdata;

    sdl_bclk_watch #(.TIMEOUT(TIMEOUT), .SYNC(2)) watch_i (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .bclk    (bclk),
        .flush   (flush)
    );

    // Both sources are flop outputs; assertion is immediate, release is synchronised
    assign arst_b_n = rst_n & ~flush;

    sdl_rst_sync #(.STAGES(2)) rsync_i (
        .clk    (bclk),
        .arst_n (arst_b_n),
        .srst_n (brst_n)
    );

    sdl_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
        .clk   (bclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    sdl_fill_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
        .bclk      (bclk),
        .brst_n    (brst_n),
        .sd_in     (sd_in),
        .ws_in     (ws_in),
        .rate_sel  (rate_sel),
        .thr_fam0  (thr_fam0),
        .thr_fam1  (thr_fam1),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .sd_out    (sd_out),
        .ws_out    (ws_out),
        .active    (dly_active),
        .ovf       (ovf)
    );
endmodule

// File: rtl/sdl_checker.sv
`timescale 1ns/1ps
module sdl_checker (
    input logic sys_clk,
    input logic rst_n,
    input logic bclk,
    input logic brst_n,
    input logic flush,
    input logic sd_out,
    input logic ws_out,
    input logic dly_active,
    input logic ovf
);
    AST_MUTED_WHEN_IDLE: assert property (@(posedge bclk) disable iff (!brst_n)
        !dly_active |-> (!sd_out && !ws_out)); // R6

    AST_ACTIVE_HOLDS: assert property (@(posedge bclk) disable iff (!brst_n)
        dly_active |=> dly_active); // R7

    AST_OVF_STICKY: assert property (@(posedge bclk) disable iff (!brst_n)
        ovf |=> ovf); // R8

    AST_OVF_NEVER_ACTIVE: assert property (@(posedge bclk) disable iff (!brst_n)
        ovf |-> !dly_active); // R8

    AST_FLUSH_CLEARS: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (flush && $past(flush)) |-> (!dly_active && !ovf && !sd_out && !ws_out)); // R9
endmodule

bind sdl_top sdl_checker chk_i (
    .sys_clk    (sys_clk),
    .rst_n      (rst_n),
    .bclk       (bclk),
    .brst_n     (brst_n),
    .flush      (flush),
    .sd_out     (sd_out),
    .ws_out     (ws_out),
    .dly_active (dly_active),
    .ovf        (ovf)
);

// File: tb/sdl_top_tb_top.sv
`timescale 1ns/1ps
module sdl_top_tb_top;
    localparam int DEPTH   = 16;
    localparam int TIMEOUT = 32;
    localparam int CW      = $clog2(DEPTH) + 1;

    logic          sys_clk = 1'b0;
    logic          bclk    = 1'b0;
    logic          bclk_run = 1'b1;
    logic          rst_n   = 1'b0;
    logic          sd_in = 1'b0, ws_in = 1'b0, rate_sel = 1'b0;
    logic [CW-1:0] thr_fam0 = '0, thr_fam1 = '0;
    logic          sd_out, ws_out, dly_active, ovf;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // scoreboard state
    logic [1:0] exp_q[$];
    int    k      = -1;   // storing-edge index
    int    skip   = 0;    // edges still consumed by reset release
    int    t_cur  = 1;    // threshold the model expects
    bit    mon_on = 1'b0;
    string cur_req = "R4";

    sdl_top #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) dut_i (
        .sys_clk(sys_clk), .rst_n(rst_n), .bclk(bclk), .sd_in(sd_in), .ws_in(ws_in),
        .rate_sel(rate_sel), .thr_fam0(thr_fam0), .thr_fam1(thr_fam1),
        .sd_out(sd_out), .ws_out(ws_out), .dly_active(dly_active), .ovf(ovf)
    );

    always #2.5 sys_clk = ~sys_clk;
    initial forever begin
        #20;
        if (bclk_run) bclk = ~bclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // driver: stimulus plus expected pairs into the queue
    task automatic run_edges(input int n);
        for (int i = 0; i < n; i++) begin
            sd_in = 1'($urandom);
            ws_in = 1'($urandom);
            @(posedge bclk);
            if (skip > 0) begin
                skip--;
            end else begin
                k++;
                if (t_cur <= DEPTH) exp_q.push_back({sd_in, ws_in});
            end
            @(negedge bclk);
        end
    endtask

    // monitor: pops and compares away from the active edge
    always @(negedge bclk) begin
        if (mon_on) begin
            bit exp_act;
            bit exp_ovf;
            exp_act = (t_cur <= DEPTH) && (k >= t_cur);
            exp_ovf = (t_cur > DEPTH) && (k >= DEPTH);
            check(dly_active == exp_act, {cur_req, " active"}, dly_active, exp_act);
            check(ovf == exp_ovf, {cur_req, " R8 ovf"}, ovf, exp_ovf);
            if (exp_act) begin
                logic [1:0] e;
                if (exp_q.size() == 0) begin
                    check(1'b0, {cur_req, " queue empty"}, 0, 1);
                end else begin
                    e = exp_q.pop_front();
                    check({sd_out, ws_out} == e, {cur_req, " delayed pair"}, {sd_out, ws_out}, e);
                end
            end else begin
                check({sd_out, ws_out} == 2'b00, "R6 muted output", {sd_out, ws_out}, 0);
            end
        end
    end

    task automatic stop_and_flush(input string req);
        @(negedge bclk);
        mon_on = 1'b0;
        #10 bclk_run = 1'b0;
        repeat (TIMEOUT + 30) @(posedge sys_clk);
        #1;
        check(dly_active == 1'b0, {req, " flush active"}, dly_active, 0);
        check(ovf == 1'b0, {req, " flush ovf"}, ovf, 0);
        check({sd_out, ws_out} == 2'b00, {req, " flush outputs"}, {sd_out, ws_out}, 0);
        exp_q.delete();
    endtask

    task automatic resume(input int t_exp, input string req);
        t_cur = t_exp; k = -1; skip = 3; cur_req = req;
        mon_on = 1'b1;
        bclk_run = 1'b1;
    endtask

    initial begin
        thr_fam0 = CW'(5); thr_fam1 = CW'(9); rate_sel = 1'b0;
        repeat (6) @(posedge sys_clk);
        #1;
        check({sd_out, ws_out, dly_active, ovf} == 4'b0, "R1 reset state",
              {sd_out, ws_out, dly_active, ovf}, 0);
        // release reset during a low bit-clock phase
        @(negedge bclk); #10;
        rst_n = 1'b1;
        t_cur = 5; k = -1; skip = 2; cur_req = "R2/R3/R4";
        mon_on = 1'b1;
        run_edges(16);
        // R7: threshold inputs change mid-stream, delay must stay at 5
        thr_fam0 = CW'(3); thr_fam1 = CW'(2); rate_sel = 1'b1;
        cur_req = "R7";
        run_edges(16);

        stop_and_flush("R9");
        // family 1 selected, T = 2 after recapture
        resume(2, "R10/R3");
        run_edges(20);

        stop_and_flush("R9");
        thr_fam1 = CW'(9);
        resume(9, "R10/R3");
        run_edges(24);

        stop_and_flush("R9");
        rate_sel = 1'b0; thr_fam0 = '0;
        resume(1, "R5");
        run_edges(12);

        stop_and_flush("R9");
        thr_fam0 = CW'(DEPTH);
        resume(DEPTH, "R4 full depth");
        run_edges(36);

        stop_and_flush("R9");
        thr_fam0 = CW'(DEPTH + 4);
        resume(DEPTH + 4, "R8");
        run_edges(28);
        check(ovf == 1'b1, "R8 overflow raised", ovf, 1);
        stop_and_flush("R9 clears overflow");

        // back to reset: R1 again
        rst_n = 1'b0;
        #1;
        check({sd_out, ws_out, dly_active, ovf} == 4'b0, "R1 reset state",
              {sd_out, ws_out, dly_active, ovf}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule